// File: doc/BRIEF.md
# Power-Manager Command Protocol Engine

This block is the command side of a small power-management controller, reached over a byte stream. The host sends an opcode byte, then a length byte, then that many payload bytes. The engine takes one of three actions. It can store payload bytes into a 128-byte parameter RAM. It can return a reply made of a result code, a reply length and reply data. It can also accept the request quietly. Input and output bytes each use a valid/ready handshake. Only one direction is ever open at a time.

Requests that break the length or address rules set an error flag. The flag stays set until reset. The engine always finishes consuming the offending request, so the byte stream stays aligned for the next command. Parameter reads return live RAM contents. A few opcodes return fixed replies: a self-test, three status queries, an internal-RAM probe that recognises one particular three-byte payload, and an auto-poll-off command that expects no payload.

Top module: `pwr_cmd_engine`

## Requirements
- R1: After reset `inReady` is 1, `outValid` is 0, `errFlag` is 0 and all 128 parameter RAM bytes read back as 0x00.
- R2: Each request is an opcode byte, then a length byte, then exactly that many payload bytes. The engine accepts one byte per clock while `inReady` is high. `inReady` and `outValid` are never high together, and `inReady` returns to 1 once a request or its reply is finished.
- R3: Opcode 0x32 writes parameter RAM. Payload byte 0 is the start offset and byte 1 is the count. When length equals count+2 and offset+count ≤ 128, the remaining payload bytes are stored at offset, offset+1, and so on. The length is not limited to 8, and no reply is sent.
- R4: For opcode 0x32, any of the following sets `errFlag` and leaves the RAM unchanged: a length below 2, a length other than count+2, or offset+count above 128. No reply is sent.
- R5: Opcode 0x3A with length 2 and offset+count ≤ 128 replies 0x00, then count, then the RAM bytes from offset upward. Any other 0x3A request sets `errFlag` and sends no reply.
- R6: A reply is sent as result code 0x00 first, then the reply length, then the data. `outValid`/`outData` hold until `outReady`. Opcode 0xEC replies 0x00, 0x00 and the reply ends after the length byte.
- R7: Opcodes 0x78, 0x68 and 0x7F each reply 0x00, 0x01, 0x00.
- R8: Opcode 0xE8 with length 3 and payload 0x00, 0xEE, 0x01 replies 0x00, 0x01, 0x20. Any other 0xE8 request replies 0x00, 0x01, 0x00.
- R9: Opcode 0x21 sends no reply. If its length is nonzero, `errFlag` is set.
- R10: Opcode 0x10, 0xE0 and every opcode not listed above consume their payload and send no reply. On any opcode other than 0x32, a length above 8 sets `errFlag`. All the bytes are still accepted.
- R11: `errFlag` stays set until reset, and requests that follow are still served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Host offers a byte |
| inData | input | 8 | Byte from host |
| inReady | output | 1 | Engine accepts the offered byte this cycle |
| outValid | output | 1 | Engine offers a reply byte |
| outData | output | 8 | Reply byte to host |
| outReady | input | 1 | Host takes the reply byte this cycle |
| errFlag | output | 1 | Sticky malformed-request flag |

## Verification
For a parameter write, the count byte can be stored in the payload buffer in the same cycle that it fails the bounds check and raises the error flag. Each later data byte is checked against that decision in the cycle it arrives. The bench drives request bytes back to back, with `inValid` held high across the whole request. This places the count byte, its error and the first data byte in consecutive cycles. Each case is judged by reading the RAM back through normal reads: a rejected write must leave every byte equal to the bench's model, and an accepted write must change exactly the addressed span.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam logic [7:0] OP_PWR   = 8'h32; // parameter write
  localparam logic [7:0] OP_PRD   = 8'h3A; // parameter read
  localparam logic [7:0] OP_TEST  = 8'hEC;
  localparam logic [7:0] OP_INT   = 8'h78;
  localparam logic [7:0] OP_BATT  = 8'h68;
  localparam logic [7:0] OP_SLEEP = 8'h7F;
  localparam logic [7:0] OP_IRAM  = 8'hE8;
  localparam logic [7:0] OP_POLL  = 8'h21;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEN, PH_PAY, PH_EXEC, PH_HDR, PH_DATA
  } phase_t;

  typedef enum logic [1:0] {SEL_CODE, SEL_LEN, SEL_DATA} outSel_t;
  typedef enum logic [1:0] {ACT_DONE, ACT_REPLY, ACT_FAULT} act_t;

  typedef struct packed {
    logic    capCmd;
    logic    capLen;
    logic    takeByte;
    logic    latchReply;
    logic    sendData;
    outSel_t outSel;
  } strobe_t;

  typedef struct packed {
    logic inZero;
    logic lenFault;
    logic byteFault;
    logic rxLast;
    logic repEmpty;
    logic txLast;
    act_t act;
  } status_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  input  status_t stat,
  output strobe_t strb,
  output logic    inReady,
  output logic    outValid,
  output logic    errFlag
);
  phase_t phase, nextPhase;
  logic   hdrSecond, nextHdr, setErr;

  always_comb begin
    strb      = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    nextPhase = phase;
    nextHdr   = hdrSecond;
    setErr    = 1'b0;
    case (phase)
      PH_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capCmd = 1'b1;
          nextPhase   = PH_LEN;
        end
      end
      PH_LEN: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capLen = 1'b1;
          setErr      = stat.lenFault;
          nextPhase   = stat.inZero ? PH_EXEC : PH_PAY;
        end
      end
      PH_PAY: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.takeByte = 1'b1;
          setErr        = stat.byteFault;
          if (stat.rxLast) nextPhase = PH_EXEC;
        end
      end
      PH_EXEC: begin
        strb.latchReply = 1'b1;
        if (stat.act == ACT_REPLY) begin
          nextPhase = PH_HDR;
          nextHdr   = 1'b0;
        end else begin
          nextPhase = PH_IDLE;
          setErr    = (stat.act == ACT_FAULT);
        end
      end
      PH_HDR: begin
        outValid    = 1'b1;
        strb.outSel = hdrSecond ? SEL_LEN : SEL_CODE;
        if (outReady) begin
          if (!hdrSecond) nextHdr = 1'b1;
          else nextPhase = stat.repEmpty ? PH_IDLE : PH_DATA;
        end
      end
      PH_DATA: begin
        outValid    = 1'b1;
        strb.outSel = SEL_DATA;
        if (outReady) begin
          strb.sendData = 1'b1;
          if (stat.txLast) nextPhase = PH_IDLE;
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      hdrSecond <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      phase     <= nextPhase;
      hdrSecond <= nextHdr;
      if (setErr) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/pce_data.sv
module pce_data
  import pce_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int RAM_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] inData,
  output status_t    stat,
  output logic [7:0] outData
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int BUF_AW = $clog2(BUF_DEPTH);
  localparam logic [8:0] RAM_LIMIT = 9'(RAM_DEPTH);
  localparam logic [7:0] BUF_LIMIT = 8'(BUF_DEPTH);

  logic [7:0] cmdReg, lenReg, rxIdx, txIdx, repLen, repByte;
  logic       wrBad, repFromRam;
  logic [RAM_AW-1:0] repOff;
  logic [7:0] bufMem [BUF_DEPTH];
  logic [7:0] ramMem [RAM_DEPTH];

  // bounds of a parameter write, judged when the count byte arrives
  logic [8:0] wrEnd;
  logic       wrLenOk, wrFits;
  assign wrEnd   = {1'b0, bufMem[0]} + {1'b0, inData};
  assign wrLenOk = ({1'b0, lenReg} == ({1'b0, inData} + 9'd2));
  assign wrFits  = (wrEnd <= RAM_LIMIT);

  logic [RAM_AW-1:0] wrAddr, rdAddr;
  assign wrAddr = bufMem[0][RAM_AW-1:0] + rxIdx[RAM_AW-1:0] - RAM_AW'(2);
  assign rdAddr = repOff + txIdx[RAM_AW-1:0];

  logic isPwr;
  assign isPwr = (cmdReg == OP_PWR);

  // reply decode, evaluated in the command-received phase
  act_t       decAct;
  logic [7:0] decLen, decByte;
  logic       decFromRam, rdOk, magicHit;
  logic [8:0] rdEnd;
  assign rdEnd    = {1'b0, bufMem[0]} + {1'b0, bufMem[1]};
  assign rdOk     = (lenReg == 8'd2) && (rdEnd <= RAM_LIMIT);
  assign magicHit = (lenReg == 8'd3) && (bufMem[0] == 8'h00) &&
                    (bufMem[1] == 8'hEE) && (bufMem[2] == 8'h01);

  always_comb begin
    decAct     = ACT_DONE;
    decLen     = 8'd0;
    decByte    = 8'h00;
    decFromRam = 1'b0;
    case (cmdReg)
      OP_PRD: begin
        if (rdOk) begin
          decAct     = ACT_REPLY;
          decLen     = bufMem[1];
          decFromRam = 1'b1;
        end else begin
          decAct = ACT_FAULT;
        end
      end
      OP_TEST: decAct = ACT_REPLY;
      OP_INT, OP_BATT, OP_SLEEP: begin
        decAct = ACT_REPLY;
        decLen = 8'd1;
      end
      OP_IRAM: begin
        decAct  = ACT_REPLY;
        decLen  = 8'd1;
        decByte = magicHit ? 8'h20 : 8'h00;
      end
      OP_POLL: decAct = (lenReg != 8'd0) ? ACT_FAULT : ACT_DONE;
      default: decAct = ACT_DONE;
    endcase
  end

  always_comb begin
    stat.inZero    = (inData == 8'd0);
    stat.lenFault  = isPwr ? (inData < 8'd2) : (inData > BUF_LIMIT);
    stat.byteFault = isPwr && (rxIdx == 8'd1) && !(wrLenOk && wrFits);
    stat.rxLast    = (rxIdx == lenReg - 8'd1);
    stat.repEmpty  = (repLen == 8'd0);
    stat.txLast    = (txIdx == repLen - 8'd1);
    stat.act       = decAct;
  end

  always_comb begin
    case (strb.outSel)
      SEL_LEN:  outData = repLen;
      SEL_DATA: outData = repFromRam ? ramMem[rdAddr] : repByte;
      default:  outData = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg     <= '0;
      lenReg     <= '0;
      rxIdx      <= '0;
      txIdx      <= '0;
      wrBad      <= 1'b0;
      repLen     <= '0;
      repByte    <= '0;
      repFromRam <= 1'b0;
      repOff     <= '0;
    end else begin
      if (strb.capCmd) cmdReg <= inData;
      if (strb.capLen) begin
        lenReg <= inData;
        rxIdx  <= '0;
        wrBad  <= isPwr && (inData < 8'd2);
      end
      if (strb.takeByte) begin
        rxIdx <= rxIdx + 8'd1;
        if (stat.byteFault) wrBad <= 1'b1;
      end
      if (strb.latchReply) begin
        repLen     <= decLen;
        repByte    <= decByte;
        repFromRam <= decFromRam;
        repOff     <= bufMem[0][RAM_AW-1:0];
        txIdx      <= '0;
      end
      if (strb.sendData) txIdx <= txIdx + 8'd1;
    end
  end

  // payload staging buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
    end else if (strb.takeByte && (rxIdx < BUF_LIMIT)) begin
      if (!isPwr || rxIdx < 8'd2) bufMem[rxIdx[BUF_AW-1:0]] <= inData;
    end
  end

  // parameter RAM, written straight from the stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramMem[i] <= '0;
    end else if (strb.takeByte && isPwr && (rxIdx >= 8'd2) && !wrBad) begin
      ramMem[wrAddr] <= inData;
    end
  end
endmodule

// File: rtl/pwr_cmd_engine.sv
module pwr_cmd_engine
  import pce_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int RAM_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outData,
  input  logic       outReady,
  output logic       errFlag
);
  strobe_t strb;
  status_t stat;

  pce_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .stat(stat), .strb(strb), .inReady(inReady), .outValid(outValid),
    .errFlag(errFlag)
  );

  pce_data #(.BUF_DEPTH(BUF_DEPTH), .RAM_DEPTH(RAM_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .stat(stat), .outData(outData)
  );
endmodule

// File: rtl/pce_checker.sv
module pce_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       errFlag
);
  p_one_way_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_code_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outData == 8'h00));
endmodule

bind pwr_cmd_engine pce_checker uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .errFlag(errFlag)
);

// File: tb/sim_pwr_cmd_engine.sv
module sim_pwr_cmd_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       outReady = 1'b0;
  wire        inReady, outValid, errFlag;
  wire  [7:0] outData;

  int total = 0;
  int bad = 0;
  logic [7:0] model [128];
  logic [7:0] pay [64];

  always #5 clk = ~clk;

  pwr_cmd_engine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .errFlag(errFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
  endtask

  // called at a negedge, returns at a negedge after the handshake edge
  task automatic putByte(input logic [7:0] b);
    inValid = 1'b1; inData = b;
    while (!inReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic request(input logic [7:0] op, input int len);
    putByte(op);
    putByte(8'(len));
    for (int i = 0; i < len; i++) putByte(pay[i]);
    inValid = 1'b0;
  endtask

  task automatic getByte(output logic [7:0] b);
    outReady = 1'b1;
    while (!outValid) @(negedge clk);
    b = outData;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  // expects code 0, length len, data matching pay[] (as expected bytes)
  task automatic expectReply(input string tag, input int len);
    logic [7:0] b;
    getByte(b); check({tag, " code"}, b, 0);
    getByte(b); check({tag, " len"}, b, len);
    for (int i = 0; i < len; i++) begin
      getByte(b); check({tag, " data"}, b, pay[i]);
    end
    check({tag, " R2 ready after reply"}, inReady, 1);
  endtask

  task automatic expectQuiet(input string tag);
    repeat (3) @(negedge clk);
    check({tag, " no reply"}, outValid, 0);
    check({tag, " R2 ready again"}, inReady, 1);
  endtask

  task automatic writeRam(input int off, input int cnt, input int seed);
    pay[0] = 8'(off); pay[1] = 8'(cnt);
    for (int i = 0; i < cnt; i++) pay[i + 2] = 8'((off * 5 + i * 3 + seed) & 8'hFF);
    request(8'h32, cnt + 2);
    for (int i = 0; i < cnt; i++) model[off + i] = pay[i + 2];
    expectQuiet("R3 write");
  endtask

  task automatic readCheck(input string tag, input int off, input int cnt);
    pay[0] = 8'(off); pay[1] = 8'(cnt);
    request(8'h3A, 2);
    for (int i = 0; i < cnt; i++) pay[i] = model[off + i];
    expectReply(tag, cnt);
  endtask

  task automatic readAll(input string tag);
    for (int c = 0; c < 4; c++) readCheck(tag, c * 32, 32);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    doReset();
    // R1 reset state
    check("R1 inReady", inReady, 1);
    check("R1 outValid", outValid, 0);
    check("R1 errFlag", errFlag, 0);
    readAll("R1 RAM zero R5");

    // R3 sweep of writes with back-to-back bytes, then per-span read
    for (int off = 0; off < 128; off += 7) begin
      int cnt = 1 + off % 13;
      if (off + cnt > 128) cnt = 128 - off;
      writeRam(off, cnt, off);
      readCheck("R3 R5 span", off, cnt);
    end
    writeRam(120, 8, 3);    // ends exactly at 128
    writeRam(127, 1, 9);
    writeRam(30, 20, 1);    // long write beyond buffer size
    writeRam(128, 0, 0);    // empty write at the top
    readAll("R3 full readback");
    check("R3 no error", errFlag, 0);

    // R6 R7 R8 canned replies
    request(8'hEC, 0);            expectReply("R6 selftest", 0);
    pay[0] = 8'h00;
    request(8'h78, 0); pay[0] = 8'h00; expectReply("R7 int", 1);
    request(8'h68, 0); pay[0] = 8'h00; expectReply("R7 batt", 1);
    request(8'h7F, 0); pay[0] = 8'h00; expectReply("R7 sleep", 1);
    pay[0] = 8'h00; pay[1] = 8'hEE; pay[2] = 8'h01;
    request(8'hE8, 3); pay[0] = 8'h20; expectReply("R8 magic", 1);
    pay[0] = 8'h00; pay[1] = 8'hEE; pay[2] = 8'h02;
    request(8'hE8, 3); pay[0] = 8'h00; expectReply("R8 other", 1);
    pay[0] = 8'h00; pay[1] = 8'hEE;
    request(8'hE8, 2); pay[0] = 8'h00; expectReply("R8 short", 1);

    // R9 R10 quiet opcodes without error
    request(8'h21, 0); expectQuiet("R9 poll off");
    for (int i = 0; i < 8; i++) pay[i] = 8'(i + 1);
    request(8'h10, 8); expectQuiet("R10 power");
    request(8'hE0, 3); expectQuiet("R10 pmram");
    request(8'h55, 5); expectQuiet("R10 unknown");
    check("R9 R10 no error", errFlag, 0);
    readAll("R10 RAM untouched");

    // R4 write faults, each from a fresh reset
    doReset();
    pay[0] = 8'd5; request(8'h32, 1); expectQuiet("R4 len1");
    check("R4 len below 2 err", errFlag, 1);
    readAll("R4 len1 RAM");
    doReset();
    pay[0] = 8'd10; pay[1] = 8'd3; pay[2] = 1; pay[3] = 2; pay[4] = 3; pay[5] = 4;
    request(8'h32, 6); expectQuiet("R4 mismatch");
    check("R4 length mismatch err", errFlag, 1);
    readAll("R4 mismatch RAM");
    doReset();
    pay[0] = 8'd125; pay[1] = 8'd4; pay[2] = 7; pay[3] = 7; pay[4] = 7; pay[5] = 7;
    request(8'h32, 6); expectQuiet("R4 bounds");
    check("R4 past end err", errFlag, 1);
    readAll("R4 bounds RAM");

    // R11 flag stays while later requests still work
    writeRam(0, 4, 2);
    readCheck("R11 served after error", 0, 4);
    check("R11 still set", errFlag, 1);

    // R5 read faults
    doReset();
    pay[0] = 8'd0; pay[1] = 8'd1; pay[2] = 8'd0;
    request(8'h3A, 3); expectQuiet("R5 bad len");
    check("R5 bad len err", errFlag, 1);
    doReset();
    pay[0] = 8'd100; pay[1] = 8'd29;
    request(8'h3A, 2); expectQuiet("R5 range");
    check("R5 range err", errFlag, 1);

    // R9 nonzero length
    doReset();
    pay[0] = 8'h00; request(8'h21, 1); expectQuiet("R9 nonzero");
    check("R9 nonzero err", errFlag, 1);

    // R10 oversize length consumed
    doReset();
    for (int i = 0; i < 12; i++) pay[i] = 8'hA0 + 8'(i);
    request(8'h10, 12); expectQuiet("R10 oversize");
    check("R10 oversize err", errFlag, 1);
    request(8'h78, 0); pay[0] = 8'h00; expectReply("R10 aligned after", 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule